// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers a wide vector of level-sensitive peripheral interrupt lines and folds them into a much smaller set of parent interrupt requests. The lines are split into groups of eight. Each group raises its own parent output while at least one of its lines is both high and enabled. Software masks and unmasks single lines through a small memory-mapped register window. It never writes a whole mask at once. One register sets enable bits, a second one clears them, and a third, read-only register shows which lines are pending after masking.

Four consecutive groups share one 32-bit register bank, one byte lane per group. Banks are spaced 16 bytes apart. An interrupt handler that is woken by a parent line reads the status register of that bank and picks out its own byte lane. The raw input vector is registered once before masking. The default build has 20 groups, which gives 160 inputs and 5 banks.

Top module: `irq_combiner`

## Requirements
- R1: After a synchronous active-low reset, every enable bit is 0, every group output is 0 and the read data bus is 0.
- R2: A write to bank offset 0x0 sets each enable bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R3: A write to bank offset 0x4 clears each enable bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R4: A read of offset 0x0 or 0x4 returns the bank's current enable mask. The read data bus loads on the clock edge at which the read strobe is high.
- R5: A read of offset 0xC returns the registered raw inputs ANDed with the enable mask, for all four groups in the bank. Writes to 0xC change nothing.
- R6: Input 8*n+j belongs to group n and maps to bank n/4 (base address 0x10*(n/4)), bit 8*(n%4)+j. Output n is the OR of that group's eight masked bits, and no other group output responds to that input.
- R7: An access to an offset other than 0x0, 0x4 or 0xC, or to a bank index at or above the bank count, reads as 0 and a write to it changes no enable bit.
- R8: A group output changes on the first clock edge after an input change, or on the edge that performs an enable write, and not before.
- R9: Outputs are level-sensitive. An output stays high for as long as an enabled input of its group stays high, and it drops once that input falls or is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, registered on the strobe edge |
| irq_in | input | NUM_GROUPS*8 | Raw level interrupt inputs |
| grp_irq | output | NUM_GROUPS | One parent request per group |

## Verification
The checker assumes that the inputs and the bus signals change only away from the rising edge. This lets it compare each group output with the input values sampled on the previous edge, masked by the current enables. It also assumes that a write or a read lasts exactly one cycle, so a single registered copy of the last access describes each enable update. The bench drives every input and every strobe on the falling edge and drops each strobe after one cycle. This keeps the stimulus inside both assumptions.

// File: rtl/irq_comb_pkg.sv
// Package irq_comb_pkg
// Shared constants, the access-kind encoding and helper functions for the
// interrupt combiner. Assumes 8 lines per group and 4 groups per bank.
package irq_comb_pkg;
    localparam int LANE_W        = 8;
    localparam int GRP_PER_BANK  = 4;
    localparam int BANK_W        = LANE_W * GRP_PER_BANK;
    localparam int OFF_W         = 4;

    localparam logic [OFF_W-1:0] OFF_SET  = 4'h0;
    localparam logic [OFF_W-1:0] OFF_CLR  = 4'h4;
    localparam logic [OFF_W-1:0] OFF_STAT = 4'hC;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_STAT = 2'd3
    } acc_kind_t;

    // Classify an offset inside a bank; out-of-range banks are unmapped.
    function automatic acc_kind_t decode_kind(logic [OFF_W-1:0] off, logic in_range);
        acc_kind_t k;
        k = ACC_NONE;
        if (in_range) begin
            case (off)
                OFF_SET:  k = ACC_SET;
                OFF_CLR:  k = ACC_CLR;
                OFF_STAT: k = ACC_STAT;
                default:  k = ACC_NONE;
            endcase
        end
        return k;
    endfunction

    // Bits of a bank that belong to a group that exists.
    function automatic logic [BANK_W-1:0] lane_mask(int bank, int ngroups);
        logic [BANK_W-1:0] m;
        for (int k = 0; k < BANK_W; k++)
            m[k] = ((bank * GRP_PER_BANK + k / LANE_W) < ngroups);
        return m;
    endfunction
endpackage

// File: rtl/irq_comb_decode.sv
// Module irq_comb_decode
// Splits a byte address into bank index and access kind. Purely
// combinational; assumes the low four address bits select the offset.
module irq_comb_decode
    import irq_comb_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 8,
    localparam int BIDX_W   = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BIDX_W-1:0] bank,
    output acc_kind_t         kind
);
    logic in_range;

    // Decode bank number, range check and offset kind.
    always_comb begin
        bank     = addr[ADDR_W-1:OFF_W];
        in_range = (int'(bank) < NUM_BANKS);
        kind     = decode_kind(addr[OFF_W-1:0], in_range);
    end
endmodule

// File: rtl/irq_comb_enable.sv
// Module irq_comb_enable
// Holds the enable mask of every bank. Set and clear writes act only on
// bits written as 1; bits of groups that do not exist stay 0.
module irq_comb_enable
    import irq_comb_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int NUM_BANKS  = 5,
    parameter int BIDX_W     = 4,
    localparam int PAD_W     = NUM_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  acc_kind_t         kind,
    input  logic [BIDX_W-1:0] bank,
    input  logic [BANK_W-1:0] wdata,
    output logic [PAD_W-1:0]  en_flat
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [BANK_W-1:0] VMASK = lane_mask(b, NUM_GROUPS);
        logic [BANK_W-1:0] en_r;
        logic              hit;

        assign hit = wr && (int'(bank) == b);

        // Update this bank's enables on a set or clear write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_r <= '0;
            else if (hit && kind == ACC_SET)
                en_r <= (en_r | wdata) & VMASK;
            else if (hit && kind == ACC_CLR)
                en_r <= en_r & ~wdata;
        end

        assign en_flat[b*BANK_W +: BANK_W] = en_r;
    end
endmodule

// File: rtl/irq_comb_group.sv
// Module irq_comb_group
// Masks one group's eight registered lines and ORs them into the group's
// parent request. Combinational; inputs are already registered.
module irq_comb_group
    import irq_comb_pkg::*;
(
    input  logic [LANE_W-1:0] raw,
    input  logic [LANE_W-1:0] en,
    output logic [LANE_W-1:0] pend,
    output logic              irq
);
    // Mask and reduce.
    always_comb begin
        pend = raw & en;
        irq  = |pend;
    end
endmodule

// File: rtl/irq_comb_rdmux.sv
// Module irq_comb_rdmux
// Selects the addressed bank's enable or status word and registers it on
// the read strobe. Unmapped accesses return 0.
module irq_comb_rdmux
    import irq_comb_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int BIDX_W    = 4,
    localparam int PAD_W    = NUM_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  acc_kind_t         kind,
    input  logic [BIDX_W-1:0] bank,
    input  logic [PAD_W-1:0]  en_flat,
    input  logic [PAD_W-1:0]  pend_flat,
    output logic [BANK_W-1:0] rdata
);
    logic [BANK_W-1:0] sel;

    // Pick the word of the addressed bank.
    always_comb begin
        sel = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(bank) == b) begin
                case (kind)
                    ACC_SET, ACC_CLR: sel = en_flat[b*BANK_W +: BANK_W];
                    ACC_STAT:         sel = pend_flat[b*BANK_W +: BANK_W];
                    default:          sel = '0;
                endcase
            end
        end
    end

    // Capture read data on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd)
            rdata <= sel;
    end
endmodule

// File: rtl/irq_combiner.sv
// Module irq_combiner
// Top of the grouped interrupt combiner: registers the raw inputs, keeps
// per-bank enables written through set/clear offsets, and drives one
// level request per group of eight. Assumes single-cycle bus strobes.
module irq_combiner
    import irq_comb_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 8,
    localparam int NUM_IN    = NUM_GROUPS * LANE_W,
    localparam int NUM_BANKS = (NUM_GROUPS + GRP_PER_BANK - 1) / GRP_PER_BANK,
    localparam int PAD_W     = NUM_BANKS * BANK_W,
    localparam int BIDX_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_IN-1:0] irq_in,
    output logic [NUM_GROUPS-1:0] grp_irq
);
    logic [NUM_IN-1:0] raw_q;
    logic [PAD_W-1:0]  raw_pad;
    logic [PAD_W-1:0]  en_flat;
    logic [PAD_W-1:0]  pend_flat;
    logic [BIDX_W-1:0] bank;
    acc_kind_t         kind;

    // Register raw inputs once before masking.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= '0;
        else
            raw_q <= irq_in;
    end

    assign raw_pad = PAD_W'(raw_q);

    irq_comb_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .bank (bank),
        .kind (kind)
    );

    irq_comb_enable #(.NUM_GROUPS(NUM_GROUPS), .NUM_BANKS(NUM_BANKS), .BIDX_W(BIDX_W)) u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .kind    (kind),
        .bank    (bank),
        .wdata   (bus_wdata),
        .en_flat (en_flat)
    );

    for (genvar g = 0; g < NUM_BANKS * GRP_PER_BANK; g++) begin : g_grp
        if (g < NUM_GROUPS) begin : g_live
            irq_comb_group u_group (
                .raw  (raw_pad[g*LANE_W +: LANE_W]),
                .en   (en_flat[g*LANE_W +: LANE_W]),
                .pend (pend_flat[g*LANE_W +: LANE_W]),
                .irq  (grp_irq[g])
            );
        end else begin : g_pad
            assign pend_flat[g*LANE_W +: LANE_W] = '0;
        end
    end

    irq_comb_rdmux #(.NUM_BANKS(NUM_BANKS), .BIDX_W(BIDX_W)) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (bus_rd),
        .kind      (kind),
        .bank      (bank),
        .en_flat   (en_flat),
        .pend_flat (pend_flat),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/irq_combiner_chk.sv
// Module irq_combiner_chk
// Property checker bound to irq_combiner. Keeps its own registered copy of
// the last bus access and compares enable updates, read data and group
// outputs against it. Assumes strobes last one cycle.
module irq_combiner_chk
    import irq_comb_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 8,
    localparam int NUM_IN    = NUM_GROUPS * LANE_W,
    localparam int NUM_BANKS = (NUM_GROUPS + GRP_PER_BANK - 1) / GRP_PER_BANK,
    localparam int PAD_W     = NUM_BANKS * BANK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic [NUM_IN-1:0] irq_in,
    input logic [NUM_GROUPS-1:0] grp_irq,
    input logic [PAD_W-1:0]  en_flat
);
    acc_kind_t   kind_now;
    logic        wr_q;
    acc_kind_t   kind_q;
    int          bank_q;
    logic [31:0] data_q;
    logic [31:0] en_sel;

    // Classify the current access independently of the design's decoder.
    always_comb begin
        kind_now = decode_kind(bus_addr[OFF_W-1:0],
                               int'(bus_addr[ADDR_W-1:OFF_W]) < NUM_BANKS);
    end

    // Remember the last write for the next-cycle checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            kind_q <= ACC_NONE;
            bank_q <= 0;
            data_q <= '0;
        end else begin
            wr_q   <= bus_wr;
            kind_q <= kind_now;
            bank_q <= int'(bus_addr[ADDR_W-1:OFF_W]);
            data_q <= bus_wdata;
        end
    end

    // Enable word of the bank written last.
    always_comb begin
        en_sel = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (bank_q == b) en_sel = en_flat[b*BANK_W +: BANK_W];
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (grp_irq == '0 && bus_rdata == '0 && en_flat == '0));

    p_set_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q && kind_q == ACC_SET) |->
        ((en_sel & data_q & lane_mask(bank_q, NUM_GROUPS)) == (data_q & lane_mask(bank_q, NUM_GROUPS))));

    p_clear_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q && kind_q == ACC_CLR) |-> ((en_sel & data_q) == '0));

    p_unmapped_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && kind_now == ACC_NONE) |=> (bus_rdata == '0));

    p_other_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && kind_now != ACC_SET && kind_now != ACC_CLR) |=> $stable(en_flat));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        // R6 and R8: output follows last-edge inputs masked by enables.
        p_group_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
            grp_irq[g] == |($past(irq_in[g*LANE_W +: LANE_W]) & en_flat[g*LANE_W +: LANE_W]));
    end
endmodule

bind irq_combiner irq_combiner_chk #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .grp_irq   (grp_irq),
    .en_flat   (en_flat)
);

// File: tb/irq_combiner_tb.sv
// Directed bench for irq_combiner: one task per scenario, each checking
// its own results against values worked out from the requirements.
module irq_combiner_tb;
    localparam int NG = 20;
    localparam int NI = NG * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NI-1:0] irq_in = '0;
    logic [NG-1:0] grp_irq;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    irq_combiner #(.NUM_GROUPS(NG), .ADDR_W(8)) u_dut (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_wdata (bus_wdata), .bus_rd (bus_rd), .bus_rdata (bus_rdata),
        .irq_in (irq_in), .grp_irq (grp_irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_inputs(input logic [NI-1:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1", "outputs after reset", 32'(grp_irq), 32'h0);
        chk("R1", "rdata after reset", bus_rdata, 32'h0);
        bus_read(8'h00, d); chk("R1", "bank0 enables", d, 32'h0);
        bus_read(8'h44, d); chk("R1", "bank4 enables", d, 32'h0);
        chk("R1", "outputs with all inputs high", 32'(grp_irq), 32'h0);
    endtask

    task automatic t_set();
        logic [31:0] d;
        bus_write(8'h00, 32'h0000_00A5);
        bus_read(8'h00, d); chk("R2", "first set", d, 32'h0000_00A5);
        bus_write(8'h00, 32'h0000_0100);
        bus_read(8'h00, d); chk("R2", "zeros keep bits", d, 32'h0000_01A5);
        bus_write(8'h40, 32'hFF00_0000);
        bus_read(8'h44, d); chk("R4", "read via clear offset", d, 32'hFF00_0000);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        bus_write(8'h04, 32'h0000_0004);
        bus_read(8'h00, d); chk("R3", "clear one bit", d, 32'h0000_01A1);
        bus_write(8'h44, 32'h0F00_0000);
        bus_read(8'h40, d); chk("R3", "clear nibble", d, 32'hF000_0000);
    endtask

    task automatic t_status();
        logic [31:0] d;
        set_inputs('1);
        bus_read(8'h0C, d); chk("R5", "bank0 status", d, 32'h0000_01A1);
        bus_read(8'h4C, d); chk("R5", "bank4 status", d, 32'hF000_0000);
        bus_read(8'h1C, d); chk("R5", "bank1 status", d, 32'h0);
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_read(8'h00, d); chk("R5", "status write ignored", d, 32'h0000_01A1);
        chk("R6", "groups 0,1,19", 32'(grp_irq), 32'h0008_0003);
    endtask

    task automatic t_group();
        logic [NI-1:0] v;
        set_inputs('0);
        bus_write(8'h30, 32'h0000_2000);
        v = '0; v[109] = 1'b1; set_inputs(v);
        chk("R6", "input 109 -> group 13", 32'(grp_irq), 32'h0000_2000);
        v = '0; v[108] = 1'b1; set_inputs(v);
        chk("R6", "disabled input 108", 32'(grp_irq), 32'h0);
        v = '0; v[0] = 1'b1; set_inputs(v);
        chk("R6", "input 0 -> group 0", 32'(grp_irq), 32'h0000_0001);
    endtask

    task automatic t_latency();
        set_inputs('0);
        @(negedge clk);
        irq_in[109] = 1'b1;
        #1 chk("R8", "before edge", 32'(grp_irq), 32'h0);
        @(negedge clk);
        chk("R8", "after edge", 32'(grp_irq), 32'h0000_2000);
        @(negedge clk);
        irq_in = '0; irq_in[110] = 1'b1;
        @(negedge clk);
        chk("R8", "disabled 110", 32'(grp_irq), 32'h0);
        bus_addr = 8'h30; bus_wdata = 32'h0000_4000; bus_wr = 1'b1;
        #1 chk("R8", "enable before edge", 32'(grp_irq), 32'h0);
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R8", "enable after edge", 32'(grp_irq), 32'h0000_2000);
    endtask

    task automatic t_level();
        logic [NI-1:0] v;
        int bad = 0;
        v = '0; v[109] = 1'b1; set_inputs(v);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (grp_irq !== NG'(32'h2000)) bad++;
        end
        chk("R9", "held cycles off", 32'(bad), 32'h0);
        set_inputs('0);
        chk("R9", "drop on input fall", 32'(grp_irq), 32'h0);
        set_inputs(v);
        bus_write(8'h34, 32'h0000_2000);
        chk("R9", "drop on disable", 32'(grp_irq), 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        set_inputs('1);
        bus_read(8'h00, d);
        bus_read(8'h08, d); chk("R7", "read offset 8", d, 32'h0);
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h50, 32'hFFFF_FFFF);
        bus_write(8'h02, 32'hFFFF_FFFF);
        bus_write(8'hF4, 32'hFFFF_FFFF);
        bus_read(8'h00, d); chk("R7", "bank0 unchanged", d, 32'h0000_01A1);
        bus_read(8'h34, d); chk("R7", "bank3 unchanged", d, 32'h0000_4000);
        bus_read(8'h50, d); chk("R7", "read bank 5", d, 32'h0);
        chk("R7", "outputs unchanged", 32'(grp_irq), 32'h0008_2003);
    endtask

    initial begin : watchdog
        #(20 * 20000);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        irq_in = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set();
        t_clear();
        t_status();
        t_group();
        t_latency();
        t_level();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule